// File: doc/BRIEF.md
# Differential and Trellis Symbol Encoder

This block turns a stream of already scrambled 4-bit data groups into 5-bit symbol indices for a 32-point constellation mapper. Of each group, the two bits that came earliest in time are differentially encoded: the pair is added modulo 4 to the encoded pair of the previous symbol. The encoded pair then drives a systematic 8-state trellis encoder. This encoder keeps three state bits with AND/XOR feedback and adds one redundant bit. The two remaining data bits pass through unchanged.

One group is accepted in each clock cycle in which `in_valid` is high. The matching symbol appears on the next cycle with `out_valid`. The differential history and the trellis state advance only on accepted groups, so idle cycles between groups do not disturb the code sequence. A synchronous active-high reset returns both memories to zero.

Top module: `tcm_sym_encoder`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_sym` = 0, and the differential history and trellis state (A, B, C) are cleared to zero.
- R2: `out_valid` is high in the cycle after a rising edge at which `in_valid` was high, and low after one at which it was low.
- R3: `out_sym[1:0]` equals `in_data[1:0]` of the accepted group (Q3 on bit 1, Q4 on bit 0).
- R4: With Q1 = `in_data[3]`, Q2 = `in_data[2]` and P = {Q1,Q2}, the output pair {Y1,Y2} = `out_sym[3:2]` equals (P + H) mod 4, where H is the previous encoded pair, Y1 being the MSB.
- R5: The differential history H becomes the new {Y1,Y2} on every accepted group and is unchanged otherwise.
- R6: With old state A, B, C, define t1 = Y1^Y2^C and t2 = Y2^B. The new state is C' = A, A' = (t2&A)^t1, B' = (Y1&A)^t2, and `out_sym[4]` (Y0) equals B'.
- R7: The trellis state does not change in cycles where `in_valid` is low.
- R8: A reset asserted in the middle of a stream makes the next group encode as if it were the first after power-up.
- R9: `out_sym` keeps its last value through cycles without an accepted group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group present on `in_data` this cycle |
| in_data | input | 4 | {Q1,Q2,Q3,Q4}, Q1 at bit 3 |
| out_valid | output | 1 | Symbol present on `out_sym` |
| out_sym | output | 5 | {Y0,Y1,Y2,Q3,Q4}, Y0 at bit 4 |

## Verification
The hardest situations to reach are the trellis transitions that depend on A being 1 together with a particular history pair. These states are reached only through a specific past sequence of groups, and it passes through the modulo-4 history. The stimulus therefore sweeps all sixteen groups back to back, and then drives a long pseudo-random stream with idle gaps. This walks the state through all eight values while a bench model tracks history and state. A reset issued while the state is nonzero shows that the clear applies to both memories.

// File: rtl/tcm_enc_pkg.sv
package tcm_enc_pkg;
    localparam int PAIR_W  = 2;
    localparam int PLAIN_W = 2;
    localparam int GROUP_W = PAIR_W + PLAIN_W;
    localparam int SYM_W   = GROUP_W + 1;
    localparam int LUT_N   = 1 << (2 * PAIR_W);

    typedef logic [PAIR_W-1:0] pair_t;

    typedef struct packed {
        pair_t               coded;  // {Q1,Q2}
        logic [PLAIN_W-1:0]  plain;  // {Q3,Q4}
    } group_t;

    typedef struct packed {
        logic                red;    // Y0
        pair_t               coded;  // {Y1,Y2}
        logic [PLAIN_W-1:0]  plain;  // {Q3,Q4}
    } symbol_t;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } trel_state_t;

    function automatic pair_t pair_add(input pair_t x, input pair_t y);
        return pair_t'(x + y);
    endfunction

    function automatic trel_state_t trel_next(input trel_state_t s, input pair_t y);
        trel_state_t n;
        logic t1, t2;
        t1  = y[1] ^ y[0] ^ s.c;
        t2  = y[0] ^ s.b;
        n.c = s.a;
        n.a = (t2 & s.a) ^ t1;
        n.b = (y[1] & s.a) ^ t2;
        return n;
    endfunction
endpackage

// File: rtl/tcm_diff_stage.sv
module tcm_diff_stage
    import tcm_enc_pkg::*;
#(
    parameter bit USE_LUT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  pair_t q_pair,
    output pair_t y_pair
);
    pair_t hist_q;

    generate
        if (USE_LUT) begin : g_lut
            pair_t lut [LUT_N];
            for (genvar i = 0; i < LUT_N; i++) begin : g_ent
                localparam logic [2*PAIR_W-1:0] IDX = (2*PAIR_W)'(i);
                assign lut[i] = pair_add(IDX[2*PAIR_W-1:PAIR_W], IDX[PAIR_W-1:0]);
            end
            assign y_pair = lut[{q_pair, hist_q}];
        end else begin : g_add
            assign y_pair = pair_add(q_pair, hist_q);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      hist_q <= '0;
        else if (adv) hist_q <= y_pair;
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(hist_q)); // R5
    AST_HIST_FROM_OUT: assert property (@(posedge clk) disable iff (rst)
        adv |=> hist_q == $past(y_pair)); // R5
endmodule

// File: rtl/tcm_trellis_stage.sv
module tcm_trellis_stage
    import tcm_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  pair_t y_pair,
    output logic  red_bit
);
    trel_state_t st_q;
    trel_state_t st_d;

    always_comb begin
        st_d    = trel_next(st_q, y_pair);
        red_bit = st_d.b;
    end

    always_ff @(posedge clk) begin
        if (rst)      st_q <= '0;
        else if (adv) st_q <= st_d;
    end

    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(st_q)); // R7
    AST_C_TRAILS_A: assert property (@(posedge clk) disable iff (rst)
        adv |=> st_q.c == $past(st_q.a)); // R6
    AST_RED_IS_B: assert property (@(posedge clk) disable iff (rst)
        adv |=> st_q.b == $past(red_bit)); // R6
endmodule

// File: rtl/tcm_sym_encoder.sv
module tcm_sym_encoder
    import tcm_enc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [GROUP_W-1:0] in_data,
    output logic               out_valid,
    output logic [SYM_W-1:0]   out_sym
);
    group_t  grp;
    pair_t   y_pair;
    logic    red_bit;
    symbol_t sym_d;
    symbol_t sym_q;
    logic    vld_q;

    assign grp = group_t'(in_data);

    tcm_diff_stage #(.USE_LUT(1'b1)) u_diff (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_valid),
        .q_pair (grp.coded),
        .y_pair (y_pair)
    );

    tcm_trellis_stage u_trel (
        .clk     (clk),
        .rst     (rst),
        .adv     (in_valid),
        .y_pair  (y_pair),
        .red_bit (red_bit)
    );

    always_comb begin
        sym_d.red   = red_bit;
        sym_d.coded = y_pair;
        sym_d.plain = grp.plain;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            sym_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) sym_q <= sym_d;
        end
    end

    assign out_valid = vld_q;
    assign out_sym   = sym_q;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2
    AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_sym[PLAIN_W-1:0] == $past(in_data[PLAIN_W-1:0])); // R3
    AST_SYM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_sym)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_sym == '0)); // R1
endmodule

// File: tb/tcm_sym_encoder_tb.sv
module tcm_sym_encoder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [3:0] in_data;
    logic       out_valid;
    logic [4:0] out_sym;

    int total = 0;
    int bad   = 0;

    logic [1:0] m_hist;
    logic       m_a, m_b, m_c;
    logic [15:0] lfsr;

    always #2 clk = ~clk;

    tcm_sym_encoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_sym(out_sym)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] model_step(input logic [3:0] g);
        logic [1:0] y;
        logic t1, t2, na, nb, nc;
        y  = 2'(g[3:2] + m_hist);
        t1 = y[1] ^ y[0] ^ m_c;
        t2 = y[0] ^ m_b;
        nc = m_a;
        na = (t2 & m_a) ^ t1;
        nb = (y[1] & m_a) ^ t2;
        m_a = na; m_b = nb; m_c = nc;
        m_hist = y;
        return {nb, y, g[1:0]};
    endfunction

    task automatic model_clear();
        m_hist = 2'b00; m_a = 1'b0; m_b = 1'b0; m_c = 1'b0;
    endtask

    // drive one group at a negedge, check the symbol at the following negedge
    task automatic send(input logic [3:0] g);
        logic [4:0] exp;
        in_valid = 1'b1;
        in_data  = g;
        exp = model_step(g);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R2", int'(out_valid), 1);
        check(out_sym[1:0] === exp[1:0], "R3", int'(out_sym[1:0]), int'(exp[1:0]));
        check(out_sym[3:2] === exp[3:2], "R4", int'(out_sym[3:2]), int'(exp[3:2]));
        check(out_sym[4] === exp[4], "R6", int'(out_sym[4]), int'(exp[4]));
    endtask

    task automatic idle(input int n);
        logic [4:0] held;
        held = out_sym;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_data  = 4'(lfsr[3:0]); // garbage on data must be ignored
            @(negedge clk);
            check(out_valid === 1'b0, "R2", int'(out_valid), 0);
            check(out_sym === held, "R9", int'(out_sym), int'(held));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 4'hF;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        model_clear();
        check(out_valid === 1'b0, "R1", int'(out_valid), 0);
        check(out_sym === 5'd0, "R1", int'(out_sym), 0);
    endtask

    task automatic test_reset_state();
        do_reset();
        // first group after reset: H=0, state zero -> Q pair 2'b10 gives Y=10, Y0=(0&0)^(0^0)=0
        send(4'b1001);
        check(out_sym === 5'b01001, "R1", int'(out_sym), 5'b01001);
    endtask

    task automatic test_sweep();
        for (int i = 0; i < 16; i++) send(4'(i));
        for (int i = 15; i >= 0; i--) send(4'(i));
    endtask

    task automatic test_gaps();
        // history and state must survive idle cycles (R5, R7)
        for (int i = 0; i < 12; i++) begin
            send(4'(3 * i + 1));
            idle(i % 3 + 1);
        end
    endtask

    task automatic test_midstream_reset();
        for (int i = 0; i < 7; i++) send(4'(lfsr[3:0] ^ 4'(i)));
        do_reset();
        // R8: same group as the first after power-up must give the same symbol
        send(4'b1001);
        check(out_sym === 5'b01001, "R8", int'(out_sym), 5'b01001);
        send(4'b1100);
        send(4'b0111);
    endtask

    task automatic test_random();
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[5:4] == 2'b00) idle(1);
            send(lfsr[3:0]);
        end
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        lfsr = 16'hACE1;
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = 4'h0;
        model_clear();
        @(negedge clk);
        test_reset_state();
        test_sweep();
        test_gaps();
        test_midstream_reset();
        test_random();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule